// File: doc/BRIEF.md
# Load-Use Stall Controller

This block guards a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) against the one data hazard that forwarding cannot cover. The hazard is a load whose result is needed by the instruction directly behind it. Each cycle the block compares the destination of a load sitting in the decode/execute register with the source registers of the instruction being decoded. On a match it freezes the program counter and the fetch/decode register for one cycle. It also sends an empty slot down the pipeline: the control fields that enter execute are cleared, while the register fields pass unchanged.

The hazard decision is purely combinational. A small register harness is built around it so the stall can be observed from the ports. The harness holds the PC, the fetch/decode register, the execute-stage control and destination, and the memory-stage control. The instruction memory is outside the block: it returns `fetch_instr_i` for the current `pc_o` in the same cycle. On the cycle after the bubble, the consumer reads the loaded value through the existing forwarding path from the writeback side, so one bubble per load-use pair is enough.

Instruction word (21 bits, MSB first): opcode[20:15], source A[14:10], source B[9:5], dest field[4:0].

Top module: `load_use_stall_ctrl`

## Requirements
- R1: While `rst_n` is low, `pc_o` is 0, both write enables are 1, `bubble_o` is 0, and `ex_ctrl_o` and `mem_ctrl_o` are 0.
- R2: When the execute stage holds a load with a non-zero destination that equals source A of the decoding instruction, `bubble_o` is 1 and `pc_we_o` and `ifid_we_o` are 0 in that same cycle. Source A counts for every opcode except NOP.
- R3: Source B is compared only for opcodes that read it: register-register ALU (opcode 1) and store (opcode 4). A match there stalls exactly as in R2.
- R4: A source-B match is ignored when the decoding instruction does not read source B. For immediate ALU (opcode 2) and load (opcode 3), the B field is the destination, so no stall results.
- R5: A load whose destination is register 0 never stalls.
- R6: During a stall the PC and the fetch/decode register keep their values. The held instruction enters execute two cycles after the stall, with its destination on `ex_dst_o`.
- R7: The cycle after a stall, `ex_ctrl_o` is all zero. One cycle later, `mem_ctrl_o` is all zero.
- R8: Each load-use pair costs exactly one stall cycle. A chain of dependent loads stalls once per link.
- R9: A non-load producer, or a load two or more instructions ahead of its consumer, causes no stall.
- R10: Opcodes are 0 NOP, 1 register ALU, 2 immediate ALU, 3 load, 4 store, and any other value acts as NOP. The control nibble is {imm, mem_write, mem_read, reg_write}, so a load in execute shows 4'b1011.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_instr_i | input | 21 | Instruction returned by instruction memory for `pc_o` |
| pc_o | output | 16 | Current fetch address (word index) |
| pc_we_o | output | 1 | PC write enable, low while stalling |
| ifid_we_o | output | 1 | Fetch/decode register write enable, low while stalling |
| bubble_o | output | 1 | Control-zero select for the decode/execute register |
| ex_ctrl_o | output | 4 | Control nibble held in the execute stage |
| ex_dst_o | output | 5 | Destination register held in the execute stage |
| mem_ctrl_o | output | 4 | Control nibble held in the memory stage |

## Verification
The hardest case to reach is back-to-back stalls: a load that depends on an earlier load, followed by a consumer of the second load. The second hazard only appears after the first bubble has drained and the held load has moved into execute. The stimulus builds this chain in the instruction memory, and the scoreboard predicts the stall cycles from a per-case stall pattern alone. From that pattern it derives the expected PC sequence, when the bubble should appear in execute and in memory, and the destination of the resumed instruction. Cases that must not stall are also covered: a B-field match on an instruction that does not read B, and a register-0 load.

// File: rtl/lus_pkg.sv
package lus_pkg;

    localparam int OPC_W = 6;

    localparam logic [OPC_W-1:0] OPC_NOP     = 6'd0;
    localparam logic [OPC_W-1:0] OPC_ALU_RR  = 6'd1;
    localparam logic [OPC_W-1:0] OPC_ALU_IMM = 6'd2;
    localparam logic [OPC_W-1:0] OPC_LOAD    = 6'd3;
    localparam logic [OPC_W-1:0] OPC_STORE   = 6'd4;

    // Control that travels with an instruction toward EX/MEM/WB.
    typedef struct packed {
        logic imm;
        logic mem_write;
        logic mem_read;
        logic reg_write;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/lus_decode.sv
module lus_decode
    import lus_pkg::*;
#(
    parameter int REG_AW = 5,
    parameter int NUM_SRC = 2,
    localparam int INSTR_W = OPC_W + 3 * REG_AW
) (
    input  logic [INSTR_W-1:0]              instr_i,
    output ctrl_t                           ctrl_o,
    output logic [NUM_SRC-1:0][REG_AW-1:0]  src_o,
    output logic [NUM_SRC-1:0]              src_rd_o,
    output logic [REG_AW-1:0]               dst_o
);
    localparam int OPC_LSB = INSTR_W - OPC_W;
    localparam int SA_LSB  = OPC_LSB - REG_AW;
    localparam int SB_LSB  = SA_LSB - REG_AW;

    logic [OPC_W-1:0]  opc;
    logic [REG_AW-1:0] f_a, f_b, f_d;

    assign opc = instr_i[OPC_LSB +: OPC_W];
    assign f_a = instr_i[SA_LSB +: REG_AW];
    assign f_b = instr_i[SB_LSB +: REG_AW];
    assign f_d = instr_i[0 +: REG_AW];

    always_comb begin
        ctrl_o   = '0;
        dst_o    = '0;
        src_o    = '0;
        src_rd_o = '0;
        src_o[0] = f_a;
        if (NUM_SRC > 1) src_o[NUM_SRC-1] = f_b;
        unique case (opc)
            OPC_ALU_RR: begin
                ctrl_o.reg_write = 1'b1;
                dst_o            = f_d;
                src_rd_o         = '1;
            end
            OPC_ALU_IMM: begin
                ctrl_o.reg_write = 1'b1;
                ctrl_o.imm       = 1'b1;
                dst_o            = f_b;
                src_rd_o[0]      = 1'b1;
            end
            OPC_LOAD: begin
                ctrl_o.reg_write = 1'b1;
                ctrl_o.mem_read  = 1'b1;
                ctrl_o.imm       = 1'b1;
                dst_o            = f_b;
                src_rd_o[0]      = 1'b1;
            end
            OPC_STORE: begin
                ctrl_o.mem_write = 1'b1;
                ctrl_o.imm       = 1'b1;
                src_rd_o         = '1;
            end
            default: begin
                ctrl_o = '0;
            end
        endcase
    end
endmodule

// File: rtl/lus_detect.sv
module lus_detect #(
    parameter int REG_AW = 5,
    parameter int NUM_SRC = 2
) (
    input  logic                            ex_load_i,
    input  logic [REG_AW-1:0]               ex_dst_i,
    input  logic [NUM_SRC-1:0][REG_AW-1:0]  id_src_i,
    input  logic [NUM_SRC-1:0]              id_src_rd_i,
    output logic                            stall_o
);
    logic [NUM_SRC-1:0] hit;
    logic               dst_live;

    assign dst_live = |ex_dst_i;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        assign hit[s] = id_src_rd_i[s] && (id_src_i[s] == ex_dst_i);
    end

    assign stall_o = ex_load_i && dst_live && (|hit);
endmodule

// File: rtl/lus_pipe.sv
module lus_pipe
    import lus_pkg::*;
#(
    parameter int REG_AW = 5,
    parameter int PC_W = 16,
    localparam int INSTR_W = OPC_W + 3 * REG_AW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INSTR_W-1:0] fetch_instr_i,
    input  logic               pc_we_i,
    input  logic               ifid_we_i,
    input  logic               bubble_i,
    input  ctrl_t              id_ctrl_i,
    input  logic [REG_AW-1:0]  id_dst_i,
    output logic [PC_W-1:0]    pc_o,
    output logic [INSTR_W-1:0] ifid_o,
    output ctrl_t              ex_ctrl_o,
    output logic [REG_AW-1:0]  ex_dst_o,
    output ctrl_t              mem_ctrl_o
);
    typedef struct packed {
        logic [PC_W-1:0]    pc;
        logic [INSTR_W-1:0] ifid;
        ctrl_t              ex_ctrl;
        logic [REG_AW-1:0]  ex_dst;
        ctrl_t              mem_ctrl;
    } pipe_st_t;

    pipe_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (pc_we_i)   st_d.pc   = st_q.pc + PC_W'(1);
        if (ifid_we_i) st_d.ifid = fetch_instr_i;
        st_d.ex_ctrl  = bubble_i ? ctrl_t'('0) : id_ctrl_i;
        st_d.ex_dst   = id_dst_i;
        st_d.mem_ctrl = st_q.ex_ctrl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pc_o       = st_q.pc;
    assign ifid_o     = st_q.ifid;
    assign ex_ctrl_o  = st_q.ex_ctrl;
    assign ex_dst_o   = st_q.ex_dst;
    assign mem_ctrl_o = st_q.mem_ctrl;

    // R6
    ifid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ifid_we_i |=> $stable(ifid_o));
endmodule

// File: rtl/load_use_stall_ctrl.sv
module load_use_stall_ctrl
    import lus_pkg::*;
#(
    parameter int REG_AW = 5,
    parameter int PC_W = 16,
    localparam int NUM_SRC = 2,
    localparam int INSTR_W = OPC_W + 3 * REG_AW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [INSTR_W-1:0]  fetch_instr_i,
    output logic [PC_W-1:0]     pc_o,
    output logic                pc_we_o,
    output logic                ifid_we_o,
    output logic                bubble_o,
    output logic [CTRL_W-1:0]   ex_ctrl_o,
    output logic [REG_AW-1:0]   ex_dst_o,
    output logic [CTRL_W-1:0]   mem_ctrl_o
);
    logic [INSTR_W-1:0]             ifid;
    ctrl_t                          id_ctrl, ex_ctrl, mem_ctrl;
    logic [NUM_SRC-1:0][REG_AW-1:0] id_src;
    logic [NUM_SRC-1:0]             id_src_rd;
    logic [REG_AW-1:0]              id_dst, ex_dst;
    logic                           stall;

    lus_decode #(.REG_AW(REG_AW), .NUM_SRC(NUM_SRC)) u_dec (
        .instr_i  (ifid),
        .ctrl_o   (id_ctrl),
        .src_o    (id_src),
        .src_rd_o (id_src_rd),
        .dst_o    (id_dst)
    );

    lus_detect #(.REG_AW(REG_AW), .NUM_SRC(NUM_SRC)) u_det (
        .ex_load_i   (ex_ctrl.mem_read),
        .ex_dst_i    (ex_dst),
        .id_src_i    (id_src),
        .id_src_rd_i (id_src_rd),
        .stall_o     (stall)
    );

    lus_pipe #(.REG_AW(REG_AW), .PC_W(PC_W)) u_pipe (
        .clk           (clk),
        .rst_n         (rst_n),
        .fetch_instr_i (fetch_instr_i),
        .pc_we_i       (pc_we_o),
        .ifid_we_i     (ifid_we_o),
        .bubble_i      (bubble_o),
        .id_ctrl_i     (id_ctrl),
        .id_dst_i      (id_dst),
        .pc_o          (pc_o),
        .ifid_o        (ifid),
        .ex_ctrl_o     (ex_ctrl),
        .ex_dst_o      (ex_dst),
        .mem_ctrl_o    (mem_ctrl)
    );

    assign pc_we_o    = !stall;
    assign ifid_we_o  = !stall;
    assign bubble_o   = stall;
    assign ex_ctrl_o  = ex_ctrl;
    assign ex_dst_o   = ex_dst;
    assign mem_ctrl_o = mem_ctrl;

    // R8
    single_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall);
    // R6
    pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> $stable(pc_o));
    // R7
    ex_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (ex_ctrl_o == '0));
    // R7
    mem_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> ##1 (mem_ctrl_o == '0));
    // R5
    zero_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_ctrl.mem_read && ex_dst == '0) |-> !stall);
    // R9
    non_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_ctrl.mem_read |-> !stall);
endmodule

// File: tb/tb_load_use_stall_ctrl.sv
module tb_load_use_stall_ctrl;
    localparam int IW = 21;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [IW-1:0] fetch_instr;
    logic [15:0]   pc_o;
    logic          pc_we_o, ifid_we_o, bubble_o;
    logic [3:0]    ex_ctrl_o, mem_ctrl_o;
    logic [4:0]    ex_dst_o;
    logic [IW-1:0] prog [16];

    int n_chk = 0;
    int n_fail = 0;

    typedef struct {
        bit    stall;
        int    pc;
        bit    ex_zero;
        bit    mem_zero;
        int    dst;
        string req;
    } item_t;
    item_t sb[$];

    always #10 clk = ~clk;

    assign fetch_instr = prog[pc_o[3:0]];

    load_use_stall_ctrl dut (
        .clk(clk), .rst_n(rst_n), .fetch_instr_i(fetch_instr),
        .pc_o(pc_o), .pc_we_o(pc_we_o), .ifid_we_o(ifid_we_o),
        .bubble_o(bubble_o), .ex_ctrl_o(ex_ctrl_o), .ex_dst_o(ex_dst_o),
        .mem_ctrl_o(mem_ctrl_o)
    );

    function automatic logic [IW-1:0] enc(int op, int a, int b, int d);
        return {6'(op), 5'(a), 5'(b), 5'(d)};
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic run_case(string req, logic [IW-1:0] i0, logic [IW-1:0] i1,
                            logic [IW-1:0] i2, logic [7:0] mask, int d4);
        item_t it;
        int pc;
        @(negedge clk);
        rst_n = 1'b0;
        for (int k = 0; k < 16; k++) prog[k] = '0;
        prog[0] = i0; prog[1] = i1; prog[2] = i2;
        @(negedge clk);
        pc = 0;
        for (int j = 1; j <= 7; j++) begin
            if (!mask[j-1]) pc++;
            it.stall    = mask[j];
            it.pc       = pc;
            it.ex_zero  = mask[j-1];
            it.mem_zero = (j >= 2) && mask[j-2];
            it.dst      = (j == 4) ? d4 : -1;
            it.req      = req;
            sb.push_back(it);
        end
        rst_n = 1'b1;
        wait (sb.size() == 0);
    endtask

    initial begin : monitor
        item_t it;
        forever begin
            @(posedge clk);
            #5;
            if (rst_n && sb.size() > 0) begin
                it = sb.pop_front();
                check(bubble_o == it.stall, it.req, "stall", int'(bubble_o), int'(it.stall));
                check(pc_we_o == !it.stall && ifid_we_o == !it.stall, "R2", "enables",
                      int'({pc_we_o, ifid_we_o}), it.stall ? 0 : 3);
                check(pc_o == 16'(it.pc), "R6", "pc", int'(pc_o), it.pc);
                if (it.stall)
                    check(ex_ctrl_o == 4'b1011, "R10", "ex ctrl of load", int'(ex_ctrl_o), 11);
                if (it.ex_zero)
                    check(ex_ctrl_o == 4'b0000, "R7", "ex ctrl bubble", int'(ex_ctrl_o), 0);
                if (it.mem_zero)
                    check(mem_ctrl_o == 4'b0000, "R7", "mem ctrl bubble", int'(mem_ctrl_o), 0);
                if (it.dst >= 0)
                    check(int'(ex_dst_o) == it.dst, "R6", "resumed dst", int'(ex_dst_o), it.dst);
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : driver
        for (int k = 0; k < 16; k++) prog[k] = '0;
        repeat (2) @(negedge clk);
        // R1 reset state
        check(pc_o == 0 && pc_we_o && ifid_we_o && !bubble_o, "R1", "reset outputs",
              int'({pc_o[3:0], pc_we_o, ifid_we_o, bubble_o}), 6);
        check(ex_ctrl_o == 0 && mem_ctrl_o == 0, "R1", "reset ctrl",
              int'({ex_ctrl_o, mem_ctrl_o}), 0);
        // R2: consumer reads the load result through source A
        run_case("R2", enc(3,1,3,0), enc(1,3,2,4), enc(0,0,0,0), 8'b0000_0100, 4);
        // R3: consumer reads through source B (register ALU)
        run_case("R3", enc(3,1,3,0), enc(1,2,3,6), enc(0,0,0,0), 8'b0000_0100, 6);
        // R3: store data reads through source B
        run_case("R3", enc(3,1,3,0), enc(4,1,3,0), enc(0,0,0,0), 8'b0000_0100, 0);
        // R4: immediate ALU whose B field is its destination
        run_case("R4", enc(3,1,3,0), enc(2,1,3,0), enc(0,0,0,0), 8'b0000_0000, -1);
        // R4: load whose B field is its destination
        run_case("R4", enc(3,1,3,0), enc(3,2,3,0), enc(0,0,0,0), 8'b0000_0000, -1);
        // R5: load to register 0
        run_case("R5", enc(3,1,0,0), enc(1,0,0,4), enc(0,0,0,0), 8'b0000_0000, -1);
        // R9: one independent instruction between load and consumer
        run_case("R9", enc(3,1,3,0), enc(0,0,0,0), enc(1,3,2,4), 8'b0000_0000, -1);
        // R9: non-load producer
        run_case("R9", enc(2,1,3,0), enc(1,3,2,4), enc(0,0,0,0), 8'b0000_0000, -1);
        // R8: chained loads, one stall per link
        run_case("R8", enc(3,1,3,0), enc(3,3,5,0), enc(1,5,0,7), 8'b0001_0100, 5);
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule